// File: doc/BRIEF.md
# Transmit Descriptor Queue DMA Engine

This block is a single-channel transmit DMA engine. Software builds a linked list of four-word descriptors in memory, each naming one buffer that holds one whole packet. Writing the address of the first descriptor to the head pointer starts the engine. It reads each descriptor, streams the buffer bytes to a byte-wide output with ready/valid flow control, and writes a status word back into the descriptor. It then follows the next pointer until it finds a null one.

Ownership passes between software and engine through an owner flag in the status word. Software sets it to hand a descriptor over, and the engine clears it once the packet has left. When the engine reaches the end of the list, it marks that descriptor end-of-queue and goes idle. Software that appended a descriptor too late can see this mark and restart the engine by writing the head pointer again. Each finished packet raises an interrupt and presents its descriptor address. Software acknowledges it by writing that address back.

Memory is reached through a simple word-addressed port. A request stays up until the memory acknowledges it, and only one request is outstanding at a time.

Top module: `txq_dma`

## Requirements
- R1: After reset the head pointer and the completed-descriptor address read zero, the interrupt is low, and neither a memory request nor a byte is presented.
- R2: A descriptor at byte address D is read as four words at word addresses D/4, D/4+1, D/4+2, D/4+3 in that order. Word 0 is the next pointer, word 1 the buffer pointer, word 2 holds the offset in bits 31:16 and the length in bits 15:0, and word 3 is the status.
- R3: While tx_enable is low the engine does not leave idle. A head pointer written meanwhile is held and shown on hdp_value. Processing begins once tx_enable rises.
- R4: A descriptor whose status bit 29 (owner) is clear when fetched sends no byte, gets no write-back and raises no completion; the engine goes idle with the head pointer at zero.
- R5: The bytes sent are those at byte addresses buffer+offset up to buffer+offset+length-1, in rising order. Byte k of a memory word is bits 8k+7:8k. tx_last marks the final byte. Data and tx_last hold while tx_ready is low. A length of zero sends nothing.
- R6: After the last byte, word 3 alone is written, once. The written value keeps bit 31 (start of packet), bit 30 (end of packet) and the length, clears bit 29 (owner), and sets bit 28 (end of queue) exactly when the next pointer is zero.
- R7: Descriptors with nonzero next pointers are processed in chain order. While busy, the head pointer reads the address of the descriptor in progress. After a null next pointer it reads zero.
- R8: A head-pointer write while the engine is busy has no effect on the head pointer or on the descriptors processed.
- R9: Each finished descriptor sets irq and presents its address on done_desc. A completion-pointer write equal to done_desc clears irq. A write of any other value leaves irq set.
- R10: After a descriptor has been marked end of queue, software may link a new descriptor to it and write the new address to the head pointer; the engine then sends the new descriptor.
- R11: A memory request holds its address and direction until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Allows the engine to start from idle |
| hdp_we | input | 1 | Head pointer write strobe |
| hdp_wdata | input | ADDR_W | Descriptor byte address to start from |
| hdp_value | output | ADDR_W | Head pointer: current descriptor or pending start, zero when done |
| cp_we | input | 1 | Completion pointer write strobe |
| cp_wdata | input | ADDR_W | Acknowledged descriptor address |
| irq | output | 1 | Completion interrupt, level |
| done_desc | output | ADDR_W | Address of the last finished descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge, ends the request |
| tx_valid | output | 1 | Byte output valid |
| tx_data | output | 8 | Byte output data |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Byte sink ready |

## Verification
The assertions check several properties on every cycle. A memory request and a presented byte stay stable under stall. Every write-back targets word 3 of the current descriptor with owner clear. No traffic appears while the head pointer reads zero. Completions set the interrupt with the right address, and a matching acknowledge clears it. Other behaviours need whole scenarios from the bench and cannot be seen cycle by cycle: the fetch order, the byte content across word boundaries and under backpressure, chain walking with a zero-length descriptor in the middle, end-of-queue marking, the gating by tx_enable, skipping a descriptor software still owns, ignoring a head write while busy, and the restart after end of queue.

// File: rtl/txq_pkg.sv
`timescale 1ns/1ps
package txq_pkg;

    localparam int WORD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int LANES     = WORD_W / BYTE_W;
    localparam int OFF_LSB   = 16;
    localparam int OFF_W     = WORD_W - OFF_LSB;

    // status word flag positions (software decodes these)
    localparam int SOP_BIT   = 31;
    localparam int EOP_BIT   = 30;
    localparam int OWN_BIT   = 29;
    localparam int EOQ_BIT   = 28;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t link;   // word 0: next descriptor
        word_t bufp;   // word 1: buffer byte address
        word_t span;   // word 2: offset | length
        word_t stat;   // word 3: flags | packet length
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_SEND,
        ST_WBACK
    } eng_state_t;

    function automatic logic [BYTE_W-1:0] pick_byte(input word_t w, input logic [1:0] lane);
        return w[BYTE_W*lane +: BYTE_W];
    endfunction

    function automatic word_t status_wb(input word_t stat, input logic end_of_queue);
        word_t r;
        r = stat;
        r[OWN_BIT] = 1'b0;
        r[EOQ_BIT] = end_of_queue;
        return r;
    endfunction

endpackage

// File: rtl/txq_cmpl.sv
`timescale 1ns/1ps
module txq_cmpl #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmpl,
    input  logic [ADDR_W-1:0] cmpl_addr,
    input  logic              cp_we,
    input  logic [ADDR_W-1:0] cp_wdata,
    output logic              irq,
    output logic [ADDR_W-1:0] done_desc
);

    logic              irq_q;
    logic [ADDR_W-1:0] done_q;

    // a new completion wins over a same-cycle acknowledge
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            done_q <= '0;
        end else if (cmpl) begin
            irq_q  <= 1'b1;
            done_q <= cmpl_addr;
        end else if (cp_we && (cp_wdata == done_q)) begin
            irq_q  <= 1'b0;
        end
    end

    assign irq       = irq_q;
    assign done_desc = done_q;

endmodule

// File: rtl/txq_engine.sv
`timescale 1ns/1ps
module txq_engine
    import txq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tx_enable,
    input  logic                hdp_we,
    input  logic [ADDR_W-1:0]   hdp_wdata,
    output logic [ADDR_W-1:0]   hdp_value,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-3:0]   mem_addr,
    output word_t               mem_wdata,
    input  word_t               mem_rdata,
    input  logic                mem_ack,
    output logic                tx_valid,
    output logic [BYTE_W-1:0]   tx_data,
    output logic                tx_last,
    input  logic                tx_ready,
    output logic                cmpl,
    output logic [ADDR_W-1:0]   cmpl_addr
);

    localparam int MEM_AW = ADDR_W - 2;

    eng_state_t        state;
    logic [ADDR_W-1:0] head_q;
    logic [1:0]        widx;
    desc_t             dsc;
    logic [ADDR_W-1:0] cur_q;
    logic [LEN_W-1:0]  left_q;
    word_t             word_q;

    logic [ADDR_W-1:0] link_a;
    logic [LEN_W-1:0]  fetch_len;
    logic [ADDR_W-1:0] fetch_start;

    assign link_a      = dsc.link[ADDR_W-1:0];
    assign fetch_len   = dsc.span[LEN_W-1:0];
    assign fetch_start = dsc.bufp[ADDR_W-1:0] + ADDR_W'(dsc.span[OFF_LSB +: OFF_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            head_q    <= '0;
            widx      <= '0;
            dsc       <= '0;
            cur_q     <= '0;
            left_q    <= '0;
            word_q    <= '0;
            cmpl      <= 1'b0;
            cmpl_addr <= '0;
        end else begin
            cmpl <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (hdp_we) begin
                        head_q <= hdp_wdata;
                    end else if (tx_enable && (head_q != '0)) begin
                        widx  <= '0;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        unique case (widx)
                            2'd0: dsc.link <= mem_rdata;
                            2'd1: dsc.bufp <= mem_rdata;
                            2'd2: dsc.span <= mem_rdata;
                            default: dsc.stat <= mem_rdata;
                        endcase
                        if (widx == 2'd3) begin
                            if (!mem_rdata[OWN_BIT]) begin
                                head_q <= '0;
                                state  <= ST_IDLE;
                            end else begin
                                cur_q  <= fetch_start;
                                left_q <= fetch_len;
                                state  <= (fetch_len == '0) ? ST_WBACK : ST_LOAD;
                            end
                        end else begin
                            widx <= widx + 2'd1;
                        end
                    end
                end
                ST_LOAD: begin
                    if (mem_ack) begin
                        word_q <= mem_rdata;
                        state  <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tx_ready) begin
                        cur_q  <= cur_q + ADDR_W'(1);
                        left_q <= left_q - LEN_W'(1);
                        if (left_q == LEN_W'(1)) begin
                            state <= ST_WBACK;
                        end else if (cur_q[1:0] == 2'd3) begin
                            state <= ST_LOAD;
                        end
                    end
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        cmpl      <= 1'b1;
                        cmpl_addr <= head_q;
                        widx      <= '0;
                        if (link_a == '0) begin
                            head_q <= '0;
                            state  <= ST_IDLE;
                        end else begin
                            head_q <= link_a;
                            state  <= ST_FETCH;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        unique case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = head_q[ADDR_W-1:2] + MEM_AW'(widx);
            end
            ST_LOAD: begin
                mem_req  = 1'b1;
                mem_addr = cur_q[ADDR_W-1:2];
            end
            ST_WBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = head_q[ADDR_W-1:2] + MEM_AW'(3);
            end
            default: ;
        endcase
    end

    assign mem_wdata = status_wb(dsc.stat, link_a == '0);
    assign hdp_value = head_q;
    assign tx_valid  = (state == ST_SEND);
    assign tx_data   = pick_byte(word_q, cur_q[1:0]);
    assign tx_last   = (state == ST_SEND) && (left_q == LEN_W'(1));

endmodule

// File: rtl/txq_dma.sv
`timescale 1ns/1ps
module txq_dma
    import txq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tx_enable,
    input  logic                hdp_we,
    input  logic [ADDR_W-1:0]   hdp_wdata,
    output logic [ADDR_W-1:0]   hdp_value,
    input  logic                cp_we,
    input  logic [ADDR_W-1:0]   cp_wdata,
    output logic                irq,
    output logic [ADDR_W-1:0]   done_desc,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-3:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic                mem_ack,
    output logic                tx_valid,
    output logic [BYTE_W-1:0]   tx_data,
    output logic                tx_last,
    input  logic                tx_ready
);

    logic              cmpl_pulse;
    logic [ADDR_W-1:0] cmpl_addr;

    txq_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .tx_enable (tx_enable),
        .hdp_we    (hdp_we),
        .hdp_wdata (hdp_wdata),
        .hdp_value (hdp_value),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready),
        .cmpl      (cmpl_pulse),
        .cmpl_addr (cmpl_addr)
    );

    txq_cmpl #(.ADDR_W(ADDR_W)) u_cmpl (
        .clk       (clk),
        .rst       (rst),
        .cmpl      (cmpl_pulse),
        .cmpl_addr (cmpl_addr),
        .cp_we     (cp_we),
        .cp_wdata  (cp_wdata),
        .irq       (irq),
        .done_desc (done_desc)
    );

endmodule

// File: rtl/txq_dma_chk.sv
`timescale 1ns/1ps
module txq_dma_chk
    import txq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   hdp_value,
    input logic                irq,
    input logic [ADDR_W-1:0]   done_desc,
    input logic                cp_we,
    input logic [ADDR_W-1:0]   cp_wdata,
    input logic                mem_req,
    input logic                mem_we,
    input logic [ADDR_W-3:0]   mem_addr,
    input logic [WORD_W-1:0]   mem_wdata,
    input logic                mem_ack,
    input logic                tx_valid,
    input logic                tx_ready,
    input logic [BYTE_W-1:0]   tx_data,
    input logic                tx_last,
    input logic                cmpl,
    input logic [ADDR_W-1:0]   cmpl_addr
);

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q && !rst) begin
            p_reset_r1: assert (hdp_value == '0 && done_desc == '0 && !irq && !mem_req && !tx_valid)
                else $error("reset state wrong");
        end
    end

    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_tx_hold_r5: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    p_wb_target_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> (mem_addr == hdp_value[ADDR_W-1:2] + (ADDR_W-2)'(3)) && !mem_wdata[OWN_BIT]);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        hdp_value == '0 |-> !tx_valid && !mem_req);

    p_irq_set_r9: assert property (@(posedge clk) disable iff (rst)
        cmpl |=> irq && done_desc == $past(cmpl_addr));

    p_irq_clr_r9: assert property (@(posedge clk) disable iff (rst)
        cp_we && !cmpl && cp_wdata == done_desc |=> !irq);

endmodule

bind txq_dma txq_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hdp_value (hdp_value),
    .irq       (irq),
    .done_desc (done_desc),
    .cp_we     (cp_we),
    .cp_wdata  (cp_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .cmpl      (cmpl_pulse),
    .cmpl_addr (cmpl_addr)
);

// File: tb/txq_dma_bench.sv
`timescale 1ns/1ps
module txq_dma_bench;

    localparam logic [31:0] SOP = 32'h8000_0000;
    localparam logic [31:0] EOP = 32'h4000_0000;
    localparam logic [31:0] OWN = 32'h2000_0000;
    localparam logic [31:0] EOQ = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_enable = 1'b0;
    logic        hdp_we = 1'b0;
    logic [31:0] hdp_wdata = '0;
    logic [31:0] hdp_value;
    logic        cp_we = 1'b0;
    logic [31:0] cp_wdata = '0;
    logic        irq;
    logic [31:0] done_desc;
    logic        mem_req;
    logic        mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_ready;

    int          n_chk = 0;
    int          n_err = 0;
    logic [31:0] mem [0:255];
    logic [8:0]  exp_q [$];
    logic [29:0] rd_log [$];
    int          wr_cnt = 0;
    logic        bp_en = 1'b0;
    logic [31:0] cyc = '0;

    always #2.5 clk = ~clk;

    txq_dma u_txq_dma (
        .clk(clk), .rst(rst), .tx_enable(tx_enable),
        .hdp_we(hdp_we), .hdp_wdata(hdp_wdata), .hdp_value(hdp_value),
        .cp_we(cp_we), .cp_wdata(cp_wdata), .irq(irq), .done_desc(done_desc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    // memory model: acknowledge one cycle after a request is seen
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[7:0]] = mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata <= mem[mem_addr[7:0]];
                rd_log.push_back(mem_addr);
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) tx_ready <= 1'b0;
        else     tx_ready <= !bp_en || (cyc[1:0] != 2'd0);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: every accepted byte is compared with the queue
    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected byte", {24'h0, tx_data}, 32'h0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({tx_last, tx_data} == e, "R5", "byte/last", {23'h0, tx_last, tx_data}, {23'h0, e});
            end
        end
    end

    function automatic logic [7:0] img_byte(input logic [31:0] a);
        return mem[a[9:2]][8*a[1:0] +: 8];
    endfunction

    function automatic logic [31:0] wb_word(input int len, input bit eoq);
        return SOP | EOP | 32'(len[15:0]) | (eoq ? EOQ : 32'h0);
    endfunction

    // driver: build a descriptor and push the bytes it should produce
    task automatic put_desc(input logic [31:0] at, input logic [31:0] nxt, input logic [31:0] bp,
                            input int off, input int len, input bit own, input bit expect_tx);
        mem[at[9:2]]     = nxt;
        mem[at[9:2] + 1] = bp;
        mem[at[9:2] + 2] = {off[15:0], len[15:0]};
        mem[at[9:2] + 3] = SOP | EOP | (own ? OWN : 32'h0) | 32'(len[15:0]);
        if (expect_tx) begin
            for (int k = 0; k < len; k++)
                exp_q.push_back({k == len - 1, img_byte(bp + 32'(off) + 32'(k))});
        end
    endtask

    task automatic write_head(input logic [31:0] a);
        @(negedge clk); hdp_we = 1'b1; hdp_wdata = a;
        @(negedge clk); hdp_we = 1'b0;
    endtask

    task automatic write_cp(input logic [31:0] a);
        @(negedge clk); cp_we = 1'b1; cp_wdata = a;
        @(negedge clk); cp_we = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (hdp_value != 0 && g < 4000) begin
            @(negedge clk);
            g++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++)
            mem[i] = {8'(i) ^ 8'h5A, 8'(i * 3), 8'(i + 17), 8'(i) ^ 8'hC3};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(hdp_value == 0, "R1", "head after reset", hdp_value, 0);
        chk(done_desc == 0, "R1", "done_desc after reset", done_desc, 0);
        chk(!irq && !mem_req && !tx_valid, "R1", "irq/req/valid after reset",
            {29'h0, irq, mem_req, tx_valid}, 0);

        // single descriptor crossing a word boundary
        tx_enable = 1'b1;
        put_desc(32'h40, 32'h0, 32'h200, 1, 6, 1'b1, 1'b1);
        rd_log.delete();
        write_head(32'h40);
        chk(hdp_value == 32'h40, "R7", "head while busy", hdp_value, 32'h40);
        wait_idle();
        chk(exp_q.size() == 0, "R5", "bytes left over", exp_q.size(), 0);
        for (int i = 0; i < 4; i++)
            chk(rd_log.size() > i && rd_log[i] == 30'h10 + 30'(i), "R2", "fetch order",
                rd_log.size() > i ? 32'(rd_log[i]) : 32'hFFFF_FFFF, 32'h10 + 32'(i));
        chk(mem[8'h13] == wb_word(6, 1'b1), "R6", "status after last desc", mem[8'h13], wb_word(6, 1'b1));
        chk(hdp_value == 0, "R7", "head idle", hdp_value, 0);
        chk(irq && done_desc == 32'h40, "R9", "completion", done_desc, 32'h40);

        // acknowledge with wrong, then right address
        write_cp(32'h50);
        chk(irq == 1'b1, "R9", "irq after wrong ack", {31'h0, irq}, 1);
        write_cp(32'h40);
        chk(irq == 1'b0, "R9", "irq after ack", {31'h0, irq}, 0);

        // chain of three, middle one empty, under backpressure; busy head write
        bp_en = 1'b1;
        put_desc(32'h50, 32'h60, 32'h220, 0, 3, 1'b1, 1'b1);
        put_desc(32'h60, 32'h70, 32'h240, 0, 0, 1'b1, 1'b1);
        put_desc(32'h70, 32'h0,  32'h260, 2, 9, 1'b1, 1'b1);
        put_desc(32'h80, 32'h0,  32'h280, 0, 4, 1'b1, 1'b0);
        wr_cnt = 0;
        write_head(32'h50);
        repeat (10) @(negedge clk);
        write_head(32'h80);
        chk(hdp_value != 32'h80 && hdp_value != 0, "R8", "head after busy write", hdp_value, 32'h50);
        wait_idle();
        bp_en = 1'b0;
        chk(exp_q.size() == 0, "R7", "chain bytes left", exp_q.size(), 0);
        chk(mem[8'h17] == wb_word(3, 1'b0), "R6", "first status", mem[8'h17], wb_word(3, 1'b0));
        chk(mem[8'h1B] == wb_word(0, 1'b0), "R5", "zero-length status", mem[8'h1B], wb_word(0, 1'b0));
        chk(mem[8'h1F] == wb_word(9, 1'b1), "R6", "tail status", mem[8'h1F], wb_word(9, 1'b1));
        chk(wr_cnt == 3, "R6", "write-back count", wr_cnt, 3);
        chk(mem[8'h23] == (SOP | EOP | OWN | 32'd4), "R8", "ignored desc untouched",
            mem[8'h23], SOP | EOP | OWN | 32'd4);
        chk(irq && done_desc == 32'h70, "R9", "chain completion", done_desc, 32'h70);
        write_cp(32'h70);

        // enable gating
        tx_enable = 1'b0;
        put_desc(32'h90, 32'h0, 32'h300, 0, 4, 1'b1, 1'b1);
        rd_log.delete();
        write_head(32'h90);
        repeat (40) @(negedge clk);
        chk(rd_log.size() == 0, "R3", "reads while disabled", rd_log.size(), 0);
        chk(hdp_value == 32'h90, "R3", "pending head", hdp_value, 32'h90);
        chk(exp_q.size() == 4, "R3", "bytes while disabled", exp_q.size(), 4);
        tx_enable = 1'b1;
        wait_idle();
        chk(exp_q.size() == 0 && done_desc == 32'h90, "R3", "run after enable", done_desc, 32'h90);

        // descriptor still owned by software
        put_desc(32'hA0, 32'h0, 32'h320, 0, 5, 1'b0, 1'b0);
        wr_cnt = 0;
        write_head(32'hA0);
        wait_idle();
        chk(mem[8'h2B] == (SOP | EOP | 32'd5), "R4", "unowned status", mem[8'h2B], SOP | EOP | 32'd5);
        chk(wr_cnt == 0, "R4", "no write-back", wr_cnt, 0);
        chk(hdp_value == 0 && done_desc == 32'h90 && irq, "R4", "no completion", done_desc, 32'h90);
        write_cp(32'h90);

        // end of queue, late append and restart
        put_desc(32'hB0, 32'h0, 32'h340, 3, 2, 1'b1, 1'b1);
        write_head(32'hB0);
        wait_idle();
        chk((mem[8'h2F] & (OWN | EOQ)) == EOQ, "R10", "eoq seen by software", mem[8'h2F], EOQ);
        put_desc(32'hC0, 32'h0, 32'h360, 0, 3, 1'b1, 1'b1);
        mem[8'h2C] = 32'hC0;
        write_head(32'hC0);
        wait_idle();
        chk(exp_q.size() == 0 && done_desc == 32'hC0, "R10", "restart sent", done_desc, 32'hC0);
        chk(mem[8'h33] == wb_word(3, 1'b1), "R10", "restart status", mem[8'h33], wb_word(3, 1'b1));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule